// File: doc/BRIEF.md
# Byte-Lane Host Bus Slave

This block sits between a 16-bit host processor bus and a display controller's internals. The host drives an active-low chip select, one write enable and one read strobe per data byte, a 17-bit word address and a target-select line. The block steers each access either to the video memory request port or to the internal register port. Byte addresses span 256 KB: the word address carries byte-address bits 17..1 and byte-address bit 0 is implied by the byte lane, with the even byte on the low data lane.

Register accesses finish at once, with no wait. Memory accesses raise a wait output from the cycle the strobe is first seen until the cycle the memory port acknowledges. The memory request keeps its address, byte mask and write data steady until that acknowledge. The wait output can be set active-high or active-low by a configuration input. Read data reaches the host lanes only while chip select and that lane's read strobe are both asserted. Each strobe assertion makes exactly one request. After the access completes, the block waits for the strobes to be released before it accepts another access.

Top module: `hbus_slave`

## Requirements
- R1: With `sel_mem` = 1 an access raises `mem_req` only; with `sel_mem` = 0 it raises `reg_req` only; the two requests are never high together.
- R2: The byte mask sent on a write (`mem_be` / `reg_be`) has bit 0 set for `wr_n[0]` low (data bits 7:0) and bit 1 set for `wr_n[1]` low (data bits 15:8). A byte whose enable is high is left unchanged in the target.
- R3: `rd_n[0]` low returns the low byte on `rdata[7:0]` and `rd_n[1]` low returns the high byte on `rdata[15:8]`. A lane whose read strobe is high reads as zero.
- R4: `mem_addr` equals `host_addr`, which is the word address. The byte at the even byte address travels on data bits 7:0.
- R5: With `wait_pol` = 1 the wait output is high while asserted. With `wait_pol` = 0 it is low while asserted.
- R6: While `cs_n` is high, strobes make no request, do not assert wait, do not drive read data, and change no stored byte.
- R7: For a memory access, wait is asserted from the cycle the strobe appears until the cycle `mem_ack` is high, which is 3 + L cycles for a memory that acknowledges L cycles after seeing the request. Wait is deasserted the cycle after the acknowledge. A register access never asserts wait.
- R8: `rdata_oe` is 1 exactly while `cs_n` is low and at least one read strobe is low. A write-only access keeps it at 0.
- R9: A synchronous reset (`rst` high) returns the sequencer to idle with wait deasserted and no memory request, even in the middle of an access.
- R10: One strobe assertion makes exactly one request, however long the strobes stay asserted.
- R11: While `mem_req` is high and not acknowledged, `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| sel_mem | input | 1 | 1 = video memory, 0 = register file |
| host_addr | input | 17 | Word address (byte address bits 17..1) |
| wr_n | input | 2 | Byte write enables, active low |
| rd_n | input | 2 | Byte read strobes, active low |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, lanes gated by strobes |
| rdata_oe | output | 1 | Read data output enable |
| wait_pol | input | 1 | Wait polarity: 1 active high, 0 active low |
| wait_out | output | 1 | Wait to host |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 17 | Memory word address |
| mem_be | output | 2 | Memory byte mask |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 16 | Memory read data, valid with acknowledge |
| reg_req | output | 1 | Register request, one cycle |
| reg_we | output | 1 | Register request is a write |
| reg_addr | output | 6 | Register word address |
| reg_be | output | 2 | Register byte mask |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data, same cycle |

## Verification
A sequencer stuck outside idle shows up at once: the next access raises no request, and a stuck memory state holds wait asserted with no end. A wrong lane mask or a wrong capture register is caught one access later, when the bytes read back differ from a byte-wise merge computed in the bench. A miscounted wait window shows up as a wait length that differs from 3 + L for the responder latency L used in that access, and a missing strobe-release guard shows up as a second request during one long strobe.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int HB_LANES = 2;
  localparam int HB_DW    = 8 * HB_LANES;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_HOLD = 2'd2
  } hbus_state_e;

  // Active-low strobes become an active-high per-lane mask
  function automatic logic [HB_LANES-1:0] lane_mask(input logic [HB_LANES-1:0] strobe_n);
    return ~strobe_n;
  endfunction

  // Logical wait request mapped onto the configured pin level
  function automatic logic wait_level(input logic active, input logic pol);
    return active ? pol : ~pol;
  endfunction
endpackage

// File: rtl/hbus_decode.sv
module hbus_decode
  import hbus_pkg::*;
#(
  parameter int LANES = HB_LANES
) (
  input  logic             cs_n,
  input  logic [LANES-1:0] wr_n,
  input  logic [LANES-1:0] rd_n,
  output logic             strobe_on,
  output logic             is_write,
  output logic [LANES-1:0] be
);
  logic any_rd;

  assign is_write  = (wr_n != '1);
  assign any_rd    = (rd_n != '1);
  assign strobe_on = !cs_n && (is_write || any_rd);
  assign be        = is_write ? lane_mask(wr_n) : lane_mask(rd_n);
endmodule

// File: rtl/hbus_fsm.sv
module hbus_fsm
  import hbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        strobe_on,
  input  logic        sel_mem,
  input  logic        mem_ack,
  output hbus_state_e state_q,
  output logic        start_mem,
  output logic        start_reg,
  output logic        mem_done
);
  hbus_state_e state_d;
  logic        idle;

  assign idle      = (state_q == ST_IDLE);
  assign start_mem = idle && strobe_on && sel_mem;
  assign start_reg = idle && strobe_on && !sel_mem;
  assign mem_done  = (state_q == ST_MEM) && mem_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_mem)      state_d = ST_MEM;
        else if (start_reg) state_d = ST_HOLD;
      end
      ST_MEM:  if (mem_ack)    state_d = ST_HOLD;
      ST_HOLD: if (!strobe_on) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/hbus_lanes.sv
module hbus_lanes
  import hbus_pkg::*;
#(
  parameter int LANES = HB_LANES
) (
  input  logic               cs_n,
  input  logic [LANES-1:0]   rd_n,
  input  logic [8*LANES-1:0] src,
  output logic [8*LANES-1:0] rdata,
  output logic               rdata_oe
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata[8*g +: 8] = (!cs_n && !rd_n[g]) ? src[8*g +: 8] : 8'h00;
  end

  assign rdata_oe = !cs_n && (rd_n != '1);
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
  import hbus_pkg::*;
#(
  parameter int AW  = 17,
  parameter int RAW = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                sel_mem,
  input  logic [AW-1:0]       host_addr,
  input  logic [HB_LANES-1:0] wr_n,
  input  logic [HB_LANES-1:0] rd_n,
  input  logic [HB_DW-1:0]    wdata,
  output logic [HB_DW-1:0]    rdata,
  output logic                rdata_oe,
  input  logic                wait_pol,
  output logic                wait_out,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [HB_LANES-1:0] mem_be,
  output logic [HB_DW-1:0]    mem_wdata,
  input  logic                mem_ack,
  input  logic [HB_DW-1:0]    mem_rdata,
  output logic                reg_req,
  output logic                reg_we,
  output logic [RAW-1:0]      reg_addr,
  output logic [HB_LANES-1:0] reg_be,
  output logic [HB_DW-1:0]    reg_wdata,
  input  logic [HB_DW-1:0]    reg_rdata
);
  // Named internal events (observed by the bound checker)
  logic                strobe_on;
  logic                is_write;
  logic [HB_LANES-1:0] be;
  hbus_state_e         state_q;
  logic                start_mem;
  logic                start_reg;
  logic                mem_done;
  logic                wait_act;
  logic [HB_DW-1:0]    hold_q;
  logic [HB_DW-1:0]    read_src;

  hbus_decode #(.LANES(HB_LANES)) u_decode (
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .strobe_on (strobe_on),
    .is_write  (is_write),
    .be        (be)
  );

  hbus_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .strobe_on (strobe_on),
    .sel_mem   (sel_mem),
    .mem_ack   (mem_ack),
    .state_q   (state_q),
    .start_mem (start_mem),
    .start_reg (start_reg),
    .mem_done  (mem_done)
  );

  // Memory request is captured once and held until acknowledged
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
    end else if (start_mem) begin
      mem_we    <= is_write;
      mem_addr  <= host_addr;
      mem_be    <= be;
      mem_wdata <= wdata;
    end
  end

  assign mem_req = (state_q == ST_MEM);

  // Register port completes in the start cycle
  assign reg_req   = start_reg;
  assign reg_we    = is_write;
  assign reg_addr  = host_addr[RAW-1:0];
  assign reg_be    = be;
  assign reg_wdata = wdata;

  // Read holding register
  always_ff @(posedge clk) begin
    if (rst)            hold_q <= '0;
    else if (start_reg) hold_q <= reg_rdata;
    else if (mem_done)  hold_q <= mem_rdata;
  end

  assign read_src = start_reg ? reg_rdata : hold_q;

  hbus_lanes #(.LANES(HB_LANES)) u_lanes (
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .src      (read_src),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
  );

  assign wait_act = start_mem || (state_q == ST_MEM);
  assign wait_out = wait_level(wait_act, wait_pol);
endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk
  import hbus_pkg::*;
#(
  parameter int AW  = 17,
  parameter int RAW = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                cs_n,
  input logic [HB_LANES-1:0] rd_n,
  input logic                wait_pol,
  input logic                wait_out,
  input logic                mem_req,
  input logic                mem_ack,
  input logic                mem_we,
  input logic [AW-1:0]       mem_addr,
  input logic [HB_LANES-1:0] mem_be,
  input logic [HB_DW-1:0]    mem_wdata,
  input logic                reg_req,
  input logic [RAW-1:0]      reg_addr,
  input logic [HB_DW-1:0]    rdata,
  input logic                rdata_oe,
  input logic                wait_act
);
  a_r1_one_target: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && reg_req));

  a_r6_reg_needs_cs: assert property (@(posedge clk) disable iff (rst)
    reg_req |-> !cs_n);

  a_r7_wait_during_mem: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (wait_out == wait_pol));

  a_r7_no_wait_reg: assert property (@(posedge clk) disable iff (rst)
    reg_req |-> (wait_out != wait_pol));

  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (!mem_req && !wait_act));

  a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                               && $stable(mem_we) && $stable(mem_wdata)));

  a_r8_oe_needs_cs: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> (!cs_n && (rd_n != '1)));

  for (genvar g = 0; g < HB_LANES; g++) begin : g_lane_chk
    a_r3_idle_lane_zero: assert property (@(posedge clk) disable iff (rst)
      rd_n[g] |-> (rdata[8*g +: 8] == 8'h00));
  end

  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> !mem_req);

  // reg_addr is observed for completeness of the port view
  a_r1_reg_addr_known: assert property (@(posedge clk) disable iff (rst)
    reg_req |-> !$isunknown(reg_addr));
endmodule

bind hbus_slave hbus_slave_chk #(.AW(AW), .RAW(RAW)) u_chk (.*);

// File: tb/hbus_slave_tb.sv
module hbus_slave_tb;
  localparam int AW  = 17;
  localparam int RAW = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sel_mem = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [1:0]  wr_n = 2'b11;
  logic [1:0]  rd_n = 2'b11;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rdata_oe;
  logic        wait_pol = 1'b1;
  logic        wait_out;
  logic        mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        reg_req, reg_we;
  logic [RAW-1:0] reg_addr;
  logic [1:0]  reg_be;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;

  int checks = 0;
  int failures = 0;
  int lat = 0;
  int lat_cnt = 0;
  int mem_cnt = 0;
  int reg_cnt = 0;
  logic [AW-1:0] last_mem_addr = '0;
  logic [15:0] mem_m [256];
  logic [15:0] regs_m [16];
  bit done = 0;

  always #5 clk = ~clk;

  hbus_slave #(.AW(AW), .RAW(RAW)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sel_mem(sel_mem), .host_addr(host_addr),
    .wr_n(wr_n), .rd_n(rd_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .wait_pol(wait_pol), .wait_out(wait_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = regs_m[reg_addr[3:0]];

  // Memory responder and register model
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) begin
      lat_cnt <= 0;
    end else begin
      if (mem_req && !mem_ack) begin
        if (lat_cnt == lat) begin
          mem_ack <= 1'b1;
          lat_cnt <= 0;
          mem_cnt <= mem_cnt + 1;
          last_mem_addr <= mem_addr;
          mem_rdata <= mem_m[mem_addr[7:0]];
          if (mem_we) begin
            if (mem_be[0]) mem_m[mem_addr[7:0]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem_m[mem_addr[7:0]][15:8] <= mem_wdata[15:8];
          end
        end else begin
          lat_cnt <= lat_cnt + 1;
        end
      end
      if (reg_req) begin
        reg_cnt <= reg_cnt + 1;
        if (reg_we) begin
          if (reg_be[0]) regs_m[reg_addr[3:0]][7:0]  <= reg_wdata[7:0];
          if (reg_be[1]) regs_m[reg_addr[3:0]][15:8] <= reg_wdata[15:8];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // One host access; returns wait length and read sample
  task automatic host_access(input logic mem, input logic [AW-1:0] a, input logic [1:0] wn,
                             input logic [1:0] rn, input logic [15:0] d, input int hold,
                             output int waits, output logic [15:0] rd, output logic oe);
    @(negedge clk);
    sel_mem = mem; host_addr = a; wdata = d; wr_n = wn; rd_n = rn; cs_n = 1'b0;
    #1;
    waits = (wait_out == wait_pol) ? 1 : 0;
    @(negedge clk); #1;
    while (wait_out == wait_pol) begin
      waits++;
      @(negedge clk); #1;
    end
    rd = rdata; oe = rdata_oe;
    repeat (hold) @(negedge clk);
    #1;
    cs_n = 1'b1; wr_n = 2'b11; rd_n = 2'b11;
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(wait_out == 1'b0, "R9 reset wait", wait_out, 0);
    chk(mem_req == 1'b0, "R9 reset mem_req", mem_req, 0);
    chk(rdata_oe == 1'b0, "R8 reset oe", rdata_oe, 0);
  endtask

  task automatic t_reg_access();
    int w; logic [15:0] r; logic oe; int mc, rc;
    mc = mem_cnt; rc = reg_cnt;
    host_access(1'b0, 17'h00003, 2'b00, 2'b11, 16'hBEEF, 0, w, r, oe);
    chk(w == 0, "R7 register write no wait", w, 0);
    chk(reg_cnt == rc + 1 && mem_cnt == mc, "R1 register write target", reg_cnt - rc, 1);
    chk(oe == 1'b0, "R8 write-only oe", oe, 0);
    host_access(1'b0, 17'h00003, 2'b11, 2'b00, 16'h0, 0, w, r, oe);
    chk(r == 16'hBEEF, "R1 register read data", r, 16'hBEEF);
    chk(oe == 1'b1, "R8 read oe", oe, 1);
    chk(mem_cnt == mc, "R1 no memory request for register", mem_cnt - mc, 0);
  endtask

  task automatic t_mem_wait(input int l);
    int w; logic [15:0] r; logic oe; int rc;
    lat = l; rc = reg_cnt;
    host_access(1'b1, 17'h00005, 2'b00, 2'b11, 16'hAAAA, 0, w, r, oe);
    chk(w == 3 + l, "R7 memory write wait length", w, 3 + l);
    chk(reg_cnt == rc, "R1 no register request for memory", reg_cnt - rc, 0);
    host_access(1'b1, 17'h00005, 2'b11, 2'b00, 16'h0, 0, w, r, oe);
    chk(w == 3 + l, "R7 memory read wait length", w, 3 + l);
    chk(r == 16'hAAAA, "R1 memory read data", r, 16'hAAAA);
  endtask

  task automatic t_partial_write();
    int w; logic [15:0] r; logic oe;
    lat = 1;
    host_access(1'b1, 17'h00005, 2'b01, 2'b11, 16'h1234, 0, w, r, oe);
    host_access(1'b1, 17'h00005, 2'b11, 2'b00, 16'h0, 0, w, r, oe);
    chk(r == 16'h12AA, "R2 high-lane-only write merge", r, 16'h12AA);
    host_access(1'b0, 17'h00003, 2'b10, 2'b11, 16'h5566, 0, w, r, oe);
    host_access(1'b0, 17'h00003, 2'b11, 2'b00, 16'h0, 0, w, r, oe);
    chk(r == 16'hBE66, "R2 low-lane-only register write", r, 16'hBE66);
  endtask

  task automatic t_byte_read();
    int w; logic [15:0] r; logic oe;
    host_access(1'b1, 17'h00005, 2'b11, 2'b10, 16'h0, 0, w, r, oe);
    chk(r == 16'h00AA, "R3 R4 low lane read (even byte)", r, 16'h00AA);
    host_access(1'b1, 17'h00005, 2'b11, 2'b01, 16'h0, 0, w, r, oe);
    chk(r == 16'h1200, "R3 R4 high lane read (odd byte)", r, 16'h1200);
  endtask

  task automatic t_address();
    int w; logic [15:0] r; logic oe;
    lat = 0;
    host_access(1'b1, 17'h00010, 2'b00, 2'b11, 16'h1111, 0, w, r, oe);
    host_access(1'b1, 17'h10011, 2'b00, 2'b11, 16'h2222, 0, w, r, oe);
    chk(last_mem_addr == 17'h10011, "R4 R11 memory word address", last_mem_addr, 17'h10011);
    host_access(1'b1, 17'h00010, 2'b11, 2'b00, 16'h0, 0, w, r, oe);
    chk(r == 16'h1111, "R4 distinct word readback", r, 16'h1111);
  endtask

  task automatic t_cs_ignored();
    int w; logic [15:0] r; logic oe; int mc, rc;
    mc = mem_cnt; rc = reg_cnt;
    @(negedge clk);
    cs_n = 1'b1; sel_mem = 1'b1; host_addr = 17'h00005; wdata = 16'hFFFF;
    wr_n = 2'b00; rd_n = 2'b00;
    repeat (4) @(negedge clk);
    #1;
    chk(wait_out == wait_pol ? 1'b0 : 1'b1, "R6 no wait without cs", wait_out, !wait_pol);
    chk(rdata_oe == 1'b0 && rdata == 16'h0, "R6 no read drive without cs", rdata, 0);
    chk(mem_cnt == mc && reg_cnt == rc && mem_req == 1'b0, "R6 no request without cs",
        mem_cnt - mc, 0);
    wr_n = 2'b11; rd_n = 2'b11;
    host_access(1'b1, 17'h00005, 2'b11, 2'b00, 16'h0, 0, w, r, oe);
    chk(r == 16'h12AA, "R6 memory unchanged", r, 16'h12AA);
  endtask

  task automatic t_polarity();
    int w; logic [15:0] r; logic oe;
    wait_pol = 1'b0; lat = 2;
    @(negedge clk); #1;
    chk(wait_out == 1'b1, "R5 idle level active-low", wait_out, 1);
    host_access(1'b1, 17'h10011, 2'b11, 2'b00, 16'h0, 0, w, r, oe);
    chk(w == 5, "R5 active-low wait length", w, 5);
    chk(r == 16'h2222, "R5 read under active-low wait", r, 16'h2222);
    #1;
    chk(wait_out == 1'b1, "R5 released level active-low", wait_out, 1);
    wait_pol = 1'b1;
  endtask

  task automatic t_single_request();
    int w; logic [15:0] r; logic oe; int mc, rc;
    lat = 0; mc = mem_cnt; rc = reg_cnt;
    host_access(1'b1, 17'h00020, 2'b11, 2'b00, 16'h0, 6, w, r, oe);
    chk(mem_cnt == mc + 1, "R10 one memory request per strobe", mem_cnt - mc, 1);
    host_access(1'b0, 17'h00004, 2'b11, 2'b00, 16'h0, 6, w, r, oe);
    chk(reg_cnt == rc + 1, "R10 one register request per strobe", reg_cnt - rc, 1);
  endtask

  task automatic t_reset_mid();
    int w; logic [15:0] r; logic oe;
    lat = 20;
    @(negedge clk);
    sel_mem = 1'b1; host_addr = 17'h00005; rd_n = 2'b00; cs_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(wait_out == wait_pol, "R7 wait held while memory busy", wait_out, wait_pol);
    rst = 1'b1;
    cs_n = 1'b1; rd_n = 2'b11;
    @(negedge clk); #1;
    chk(wait_out != wait_pol && mem_req == 1'b0, "R9 reset mid-access", wait_out, !wait_pol);
    rst = 1'b0; lat = 0;
    host_access(1'b1, 17'h00005, 2'b11, 2'b00, 16'h0, 0, w, r, oe);
    chk(r == 16'h12AA && w == 3, "R9 access after reset", r, 16'h12AA);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = '0;
    for (int i = 0; i < 16; i++) regs_m[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reg_access();
    t_mem_wait(0);
    t_mem_wait(3);
    t_partial_write();
    t_byte_read();
    t_address();
    t_cs_ignored();
    t_polarity();
    t_single_request();
    t_reset_mid();
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule